// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor that fetches, decodes, executes and retires one instruction on every rising clock edge. Nothing is held between phases of an instruction. The register file, the program counter and the data memory are the only state, and each new value is formed by combinational logic within the same cycle. Instruction memory and data memory are separate word arrays inside the block, so a load can read data in the same cycle as its own fetch. The program counter, the branch target and the ALU result each have a dedicated adder.

The core executes nine operations. Five are register-to-register: add, subtract, and, or, and signed set-on-less-than. The others are word load, word store, branch-if-equal and an absolute jump. A testbench preloads both memories while reset is held, then releases reset and lets the program run. Progress is visible on the program-counter output. Any architectural register can be read at any time through a combinational debug port.

Top module: `sc_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, the program counter becomes 0 and no register or memory is written.
- R2: Every instruction that is neither a taken branch nor a jump sets the program counter to its own address plus 4 at the next edge.
- R3: An instruction with opcode 000000 writes register rd (bits 15:11) with rs op rt, using 32-bit wrap-around arithmetic. The function field (bits 5:0) selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or.
- R4: Opcode 000000 with function 101010 writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: Opcode 000000 with any function value other than the five listed in R3 and R4 writes no register.
- R6: Opcode 100011 writes rt (bits 20:16) with the data-memory word at byte address rs + sign-extended bits 15:0. The word index is taken from address bits above bit 1.
- R7: Opcode 101011 stores rt into the data-memory word at byte address rs + sign-extended bits 15:0, and writes no register.
- R8: Opcode 000100 compares rs with rt. When they are equal, the next program counter is PC + 4 + (sign-extended bits 15:0 shifted left by 2), and a negative offset moves backwards. Otherwise the next program counter is PC + 4. No register or memory is written.
- R9: Opcode 000010 sets the next program counter to {PC[31:28], bits 25:0, 2'b00}.
- R10: Register 0 always reads as 0, both as an operand and on the debug port, and writes to it are discarded.
- R11: The debug port returns the register selected by `dbg_sel` combinationally. A register written at an edge is visible on the port, and as an operand to the next instruction, right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Current program counter (byte address) |
| dbg_sel | input | 5 | Register index for the debug read port |
| dbg_data | output | 32 | Contents of the selected register (0 for index 0) |

## Verification
Every instruction retires at the edge that ends its own cycle. After k edges from reset release, the program counter therefore reflects the outcome of the k-th instruction executed. The bench counts edges from the release and samples `pc_o` at the falling edge that follows the counted edge.

Register results are due at the same edge as their instruction. They are read through the debug port only after the program has reached its self-loop, which leaves the registers stable. Stores are checked by a later load in the same program, and the bench reads that load's destination register.

The ALU is swept over all ordered pairs from an 8-value operand set for all five register operations, against an arithmetic model in the bench.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int RIDX_W  = $clog2(REG_CNT);

    localparam logic [5:0] OPC_RTYPE = 6'b000000;
    localparam logic [5:0] OPC_JMP   = 6'b000010;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    // datapath steering produced by the main decoder
    typedef struct packed {
        logic dst_rd;   // write index from rd instead of rt
        logic src_imm;  // second ALU operand is the extended immediate
        logic wb_mem;   // write-back data from data memory
        logic dm_we;    // store
        logic is_beq;   // conditional branch
        logic is_jmp;   // absolute jump
    } dp_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
    import core_pkg::*;
(
    input  logic [5:0] opc_i,
    input  logic [5:0] funct_i,
    output dp_ctl_t    ctl_o,
    output alu_fn_e    fn_o,
    output logic       rf_we_o
);

    alu_op_e aop;
    logic    base_we;
    logic    fn_ok;

    // main decoder: opcode -> steering, class of ALU operation
    always_comb begin
        ctl_o   = '0;
        aop     = AOP_ADD;
        base_we = 1'b0;
        case (opc_i)
            OPC_RTYPE: begin
                ctl_o.dst_rd = 1'b1;
                base_we      = 1'b1;
                aop          = AOP_FUNCT;
            end
            OPC_LOAD: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.wb_mem  = 1'b1;
                base_we       = 1'b1;
            end
            OPC_STORE: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.dm_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctl_o.is_beq = 1'b1;
                aop          = AOP_SUB;
            end
            OPC_JMP: begin
                ctl_o.is_jmp = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // second-level decoder: operation class + function field -> ALU code
    always_comb begin
        fn_o  = ALU_ADD;
        fn_ok = 1'b1;
        case (aop)
            AOP_ADD: fn_o = ALU_ADD;
            AOP_SUB: fn_o = ALU_SUB;
            AOP_FUNCT: begin
                case (funct_i)
                    FN_ADD:  fn_o = ALU_ADD;
                    FN_SUB:  fn_o = ALU_SUB;
                    FN_AND:  fn_o = ALU_AND;
                    FN_OR:   fn_o = ALU_OR;
                    FN_SLT:  fn_o = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn_ok = 1'b0;
        endcase
    end

    assign rf_we_o = base_we & fn_ok;

endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  alu_fn_e      fn_i,
    output logic [W-1:0] y_o,
    output logic         zero_o
);

    always_comb begin
        case (fn_i)
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_SLT: y_o = ($signed(a_i) < $signed(b_i)) ? W'(1) : '0;
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [W-1:0]  wd_i,
    input  logic [AW-1:0] ra_a_i,
    input  logic [AW-1:0] ra_b_i,
    input  logic [AW-1:0] ra_d_i,
    output logic [W-1:0]  rd_a_o,
    output logic [W-1:0]  rd_b_o,
    output logic [W-1:0]  rd_d_o
);

    logic [W-1:0] bank [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign bank[g] = '0;
        end else begin : g_word
            logic         hit;
            logic [W-1:0] word_d;
            logic [W-1:0] word_q;

            // one output of the write-index decoder
            assign hit = we_i && (wa_i == AW'(g));

            always_comb begin
                word_d = word_q;
                if (hit) begin
                    word_d = wd_i;
                end
            end

            always_ff @(posedge clk) begin
                word_q <= word_d;
            end

            assign bank[g] = word_q;
        end
    end

    assign rd_a_o = bank[ra_a_i];
    assign rd_b_o = bank[ra_b_i];
    assign rd_d_o = bank[ra_d_i];

endmodule

// File: rtl/core_wmem.sv
module core_wmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] idx_i,
    input  logic [W-1:0]  wd_i,
    output logic [W-1:0]  rd_o
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[idx_i] <= wd_i;
        end
    end

    assign rd_o = mem_q[idx_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   pc_o,
    input  logic [RIDX_W-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_data
);

    localparam int IM_AW = $clog2(IMEM_WORDS);
    localparam int DM_AW = $clog2(DMEM_WORDS);

    core_state_t st_d;
    core_state_t st_q;

    logic [XLEN-1:0]   instr;
    logic [5:0]        opc;
    logic [5:0]        funct;
    logic [RIDX_W-1:0] rs_idx;
    logic [RIDX_W-1:0] rt_idx;
    logic [RIDX_W-1:0] rd_idx;
    logic [15:0]       imm;
    logic [25:0]       jfield;

    dp_ctl_t           ctl;
    alu_fn_e           alu_fn;
    logic              rf_we_dec;
    logic              rf_wr;
    logic              dm_wr;
    logic              is_jmp;
    logic              take_br;

    logic [XLEN-1:0]   rd_a;
    logic [XLEN-1:0]   rd_b;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   dm_rdata;
    logic [RIDX_W-1:0] wb_idx;
    logic [XLEN-1:0]   wb_data;

    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   br_target;
    logic [XLEN-1:0]   jmp_target;

    // instruction fetch
    core_wmem #(.W(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
        .clk   (clk),
        .we_i  (1'b0),
        .idx_i (st_q.pc[IM_AW+1:2]),
        .wd_i  ('0),
        .rd_o  (instr)
    );

    assign opc    = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign funct  = instr[5:0];
    assign imm    = instr[15:0];
    assign jfield = instr[25:0];

    core_ctrl u_ctrl (
        .opc_i   (opc),
        .funct_i (funct),
        .ctl_o   (ctl),
        .fn_o    (alu_fn),
        .rf_we_o (rf_we_dec)
    );

    // no architectural update while reset is held
    assign rf_wr  = rf_we_dec & ~rst;
    assign dm_wr  = ctl.dm_we & ~rst;
    assign is_jmp = ctl.is_jmp;

    assign wb_idx  = ctl.dst_rd ? rd_idx : rt_idx;
    assign wb_data = ctl.wb_mem ? dm_rdata : alu_y;

    core_regfile #(.W(XLEN), .N(REG_CNT)) u_rf (
        .clk    (clk),
        .we_i   (rf_wr),
        .wa_i   (wb_idx),
        .wd_i   (wb_data),
        .ra_a_i (rs_idx),
        .ra_b_i (rt_idx),
        .ra_d_i (dbg_sel),
        .rd_a_o (rd_a),
        .rd_b_o (rd_b),
        .rd_d_o (dbg_data)
    );

    assign imm_ext = {{(XLEN-16){imm[15]}}, imm};
    assign alu_b   = ctl.src_imm ? imm_ext : rd_b;

    core_alu #(.W(XLEN)) u_alu (
        .a_i    (rd_a),
        .b_i    (alu_b),
        .fn_i   (alu_fn),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    core_wmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
        .clk   (clk),
        .we_i  (dm_wr),
        .idx_i (alu_y[DM_AW+1:2]),
        .wd_i  (rd_b),
        .rd_o  (dm_rdata)
    );

    // dedicated next-address adders
    assign pc_plus4   = st_q.pc + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {st_q.pc[XLEN-1:XLEN-4], jfield, 2'b00};
    assign take_br    = ctl.is_beq & alu_zero;

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_plus4;
        if (take_br) begin
            st_d.pc = br_target;
        end
        if (is_jmp) begin
            st_d.pc = jmp_target;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o = st_q.pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   instr,
    input logic              take_br,
    input logic              is_jmp,
    input logic              rf_wr,
    input logic              dm_wr,
    input logic [RIDX_W-1:0] dbg_sel,
    input logic [XLEN-1:0]   dbg_data
);

    assert_pc_clear_R1: assert property (@(posedge clk)
        rst |=> (pc_o == '0));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!take_br && !is_jmp) |=> (pc_o == $past(pc_o) + 32'd4));

    assert_branch_target_R8: assert property (@(posedge clk) disable iff (rst)
        take_br |=> (pc_o == $past(pc_o) + 32'd4
                     + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
        is_jmp |=> (pc_o == {$past(pc_o[31:28]), $past(instr[25:0]), 2'b00}));

    assert_store_no_wb_R7: assert property (@(posedge clk) disable iff (rst)
        dm_wr |-> !rf_wr);

    assert_bad_funct_R5: assert property (@(posedge clk) disable iff (rst)
        (instr[31:26] == OPC_RTYPE && instr[5:0] != FN_ADD && instr[5:0] != FN_SUB
         && instr[5:0] != FN_AND && instr[5:0] != FN_OR && instr[5:0] != FN_SLT)
        |-> !rf_wr);

    assert_zero_reg_R10: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == '0) |-> (dbg_data == '0));

endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc_o     (pc_o),
    .instr    (instr),
    .take_br  (take_br),
    .is_jmp   (is_jmp),
    .rf_wr    (rf_wr),
    .dm_wr    (dm_wr),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] pc_o;
    logic [31:0] dbg_data;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] prog [WORDS];
    logic [31:0] vals [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core dut_i (
        .clk      (clk),
        .rst      (rst),
        .pc_o     (pc_o),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'b000000, rs, rt, rd, 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] im);
        return {op, rs, rt, im};
    endfunction

    function automatic logic [31:0] alu_model(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
    endfunction

    function automatic logic [5:0] fn_code(input int op);
        case (op)
            0: return 6'b100000;
            1: return 6'b100010;
            2: return 6'b100100;
            3: return 6'b100101;
            default: return 6'b101010;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic clear_prog();
        for (int w = 0; w < WORDS; w++) prog[w] = 32'h0000_0001; // invalid function: no-op
    endtask

    // hold reset, load memories, check the cleared PC, release at a falling edge
    task automatic start_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int w = 0; w < WORDS; w++) dut_i.u_imem.mem_q[w] = prog[w];
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pc under reset", pc_o, 32'h0);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_reg(input logic [4:0] idx, output logic [31:0] v);
        dbg_sel = idx;
        #1;
        v = dbg_data;
    endtask

    logic [31:0] r;
    localparam logic [31:0] VA = 32'h0000_1234;
    localparam logic [31:0] VB = 32'hFFFF_FF00;

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
        vals[2] = 32'hFFFF_FFFF; vals[3] = 32'h7FFF_FFFF;
        vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
        vals[6] = 32'hFFFF_FFF9; vals[7] = 32'h1234_5678;

        // ---------------- directed program ----------------
        for (int w = 0; w < WORDS; w++) dut_i.u_dmem.mem_q[w] = 32'h0;
        dut_i.u_dmem.mem_q[0]  = VA;
        dut_i.u_dmem.mem_q[1]  = VB;
        dut_i.u_dmem.mem_q[8]  = 32'd48;
        dut_i.u_dmem.mem_q[11] = 32'hCAFE_0001;
        clear_prog();
        prog[0]  = enc_i(6'b100011, 5'd0, 5'd1, 16'd0);          // lw r1,0(r0)
        prog[1]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd4);          // lw r2,4(r0)
        prog[2]  = enc_r(5'd1, 5'd2, 5'd20, 6'b100000);          // add r20
        prog[3]  = enc_r(5'd2, 5'd2, 5'd20, 6'b000001);          // bad funct -> r20
        prog[4]  = enc_r(5'd1, 5'd1, 5'd0, 6'b100000);           // write r0
        prog[5]  = enc_r(5'd0, 5'd2, 5'd21, 6'b100000);          // r21 = r0 + r2
        prog[6]  = enc_i(6'b101011, 5'd0, 5'd1, 16'd40);         // sw r1,40(r0)
        prog[7]  = enc_i(6'b100011, 5'd0, 5'd22, 16'd40);        // lw r22,40(r0)
        prog[8]  = enc_i(6'b100011, 5'd0, 5'd24, 16'd32);        // lw r24,32(r0)
        prog[9]  = enc_i(6'b100011, 5'd24, 5'd23, 16'hFFFC);     // lw r23,-4(r24)
        prog[10] = enc_r(5'd1, 5'd0, 5'd25, 6'b100000);          // r25 = A
        prog[11] = enc_i(6'b000100, 5'd1, 5'd1, 16'd1);          // beq taken
        prog[12] = enc_r(5'd2, 5'd0, 5'd25, 6'b100000);          // skipped
        prog[13] = enc_i(6'b000100, 5'd1, 5'd2, 16'd1);          // beq not taken
        prog[14] = enc_r(5'd2, 5'd0, 5'd26, 6'b100000);          // r26 = B
        prog[15] = enc_r(5'd1, 5'd0, 5'd27, 6'b100000);          // r27 = A
        prog[16] = {6'b000010, 26'd18};                          // j word 18
        prog[17] = enc_r(5'd2, 5'd0, 5'd27, 6'b100000);          // skipped
        prog[18] = enc_i(6'b101011, 5'd24, 5'd2, 16'd4);         // sw r2,4(r24)
        prog[19] = enc_i(6'b100011, 5'd0, 5'd28, 16'd52);        // lw r28,52(r0)
        prog[20] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);       // self-loop
        start_prog();
        chk("R2 pc at release", pc_o, 32'd0);
        run(1);  chk("R2 pc after one edge", pc_o, 32'd4);
        run(11); chk("R8 taken branch target", pc_o, 32'd52);
        run(1);  chk("R8 not-taken branch", pc_o, 32'd56);
        run(3);  chk("R9 jump target", pc_o, 32'd72);
        run(2);  chk("R8 backward self-loop", pc_o, 32'd80);
        run(7);  chk("R8 self-loop holds", pc_o, 32'd80);
        rd_reg(5'd1, r);  chk("R6 lw word 0", r, VA);
        rd_reg(5'd2, r);  chk("R6 lw word 1", r, VB);
        rd_reg(5'd20, r); chk("R5 bad funct leaves rd", r, VA + VB);
        rd_reg(5'd0, r);  chk("R10 r0 on debug port", r, 32'h0);
        rd_reg(5'd21, r); chk("R10 r0 as operand", r, VB);
        rd_reg(5'd22, r); chk("R7 store then load", r, VA);
        rd_reg(5'd24, r); chk("R11 load result visible", r, 32'd48);
        rd_reg(5'd23, r); chk("R6 negative offset", r, 32'hCAFE_0001);
        rd_reg(5'd25, r); chk("R8 taken branch skips", r, VA);
        rd_reg(5'd26, r); chk("R8 fall-through executes", r, VB);
        rd_reg(5'd27, r); chk("R9 jump skips", r, VA);
        rd_reg(5'd28, r); chk("R7 store via base reg", r, VB);
        @(negedge clk); rst = 1'b1;
        run(1); chk("R1 reset from running state", pc_o, 32'h0);

        // ---------------- ALU sweep: 5 ops x 8 x 8 operands ----------------
        for (int w = 0; w < 8; w++) dut_i.u_dmem.mem_q[w] = vals[w];
        for (int op = 0; op < 5; op++) begin
            for (int i = 0; i < 8; i++) begin
                clear_prog();
                for (int k = 0; k < 8; k++)
                    prog[k] = enc_i(6'b100011, 5'd0, 5'(k + 1), 16'(4 * k));
                for (int j = 0; j < 8; j++)
                    prog[8 + j] = enc_r(5'(i + 1), 5'(j + 1), 5'(9 + j), fn_code(op));
                prog[16] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);
                start_prog();
                run(3);  chk("R2 sequential pc", pc_o, 32'd12);
                run(15); chk("R8 halt address", pc_o, 32'd64);
                for (int j = 0; j < 8; j++) begin
                    rd_reg(5'(9 + j), r);
                    if (op == 4) chk("R4 slt sweep", r, alu_model(op, vals[i], vals[j]));
                    else         chk("R3 alu sweep", r, alu_model(op, vals[i], vals[j]));
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule